// File: doc/BRIEF.md
# Multi-Width Countdown Timer Bank

This block is a memory-mapped timer peripheral. It holds three countdown timers and one free-running up-counter. Two of the countdown timers are 16 bits wide and one is 32 bits wide. Each countdown timer has four registers: a reload value, a live count, a control word and an interrupt-clear strobe. It counts down on one of two tick enables and raises its own interrupt line when it underflows. After an underflow it either reloads from its reload value or wraps to all ones.

The fourth timer is a 40-bit up-counter. It advances on a third, faster tick enable and is switched on by a single enable bit. It never raises an interrupt, so software can use it as a timebase and measure time elapsed between interrupts. Tick generation from the system clock is done outside the block, and all ticks arrive here as one-cycle enables. The register bus is a plain single-cycle port: the read data is a combinational function of the address, and a write takes effect at the clock edge where the write enable is sampled.

Top module: `tmr_bank`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and all three interrupt outputs are low.
- R2: Countdown timers 0, 1 and 2 sit at bases 0x00, 0x20 and 0x80. Within each base, offset +0x0 is the reload value, +0x4 the live count, +0x8 the control word and +0xC the clear strobe, which reads zero. The free counter's low 32 bits read at 0x60 and its high word is at 0x64. Any other address reads zero.
- R3: Control bit 7 enables counting, bit 6 selects periodic (reload) mode and bit 3 selects the fast tick. The control word reads back these three bits, and every other bit reads zero.
- R4: A write to the reload register always updates the reload value. It also copies the value into the live count only while the timer is disabled. While the timer is enabled, the count is left to continue.
- R5: In periodic mode, a tick that finds the count at zero reloads the count from the reload value. A reload value of N therefore gives one underflow every N+1 selected ticks.
- R6: With bit 6 clear, a tick that finds the count at zero wraps the count to all ones of the timer's width: 0xFFFF for timers 0 and 1, and 0xFFFFFFFF for timer 2.
- R7: Every underflow sets that timer's interrupt output. The output stays high until any value is written to that timer's clear offset. If an underflow and a clear write fall in the same cycle, the interrupt stays set.
- R8: Reading the live count returns the current value, zero-extended to 32 bits. While the enable bit is clear, the count does not change.
- R9: With bit 3 clear, the timer counts on `tick_slow`. With bit 3 set, it counts on `tick_mid`. Ticks on the source that is not selected have no effect on the count.
- R10: The free counter adds one on each `tick_free` while its enable bit is set. The enable is bit 8 of the word at 0x64, and bits 7:0 of that word hold counter bits 39:32. Writes to 0x60 have no effect. The free counter never drives an interrupt.
- R11: A value written to a 16-bit timer's reload register is truncated to its low 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, one write per asserted cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_slow | input | 1 | Slow count enable for countdown timers |
| tick_mid | input | 1 | Fast count enable for countdown timers (selected by control bit 3) |
| tick_free | input | 1 | Count enable for the 40-bit free counter |
| irq_o | output | 3 | Underflow interrupt, one per countdown timer |

## Verification
Every write and every tick is sampled at a rising edge. Its effect appears on `irq_o`, and on `bus_rdata` for whatever address is presented, right after that same edge, because there is exactly one register stage. Read data has no latency of its own. The bench drives inputs shortly after each falling edge and updates its behavioural model at the rising edge. At the next falling edge it compares both outputs against the model, so each result is checked exactly one edge after the stimulus that caused it. Directed phases then cover the underflow reload and wrap, the same-cycle clear race, tick selection and freezing. A random phase mixes writes and ticks on all three sources.

// File: rtl/tmr_pkg.sv
// Package: shared types and the address map of the timer bank.
// Assumes 8-bit byte addresses and 32-bit data words.
package tmr_pkg;
    localparam int N_DOWN   = 3;
    localparam int OFS_LOAD = 0;
    localparam int OFS_CNT  = 4;
    localparam int OFS_CTL  = 8;
    localparam int OFS_CLR  = 12;
    localparam int BIT_EN   = 7;
    localparam int BIT_PER  = 6;
    localparam int BIT_SEL  = 3;
    localparam int FREE_LO  = 'h60;
    localparam int FREE_HI  = 'h64;
    localparam int FREE_EN_BIT = 8;

    typedef struct packed {
        logic en;
        logic per;
        logic sel;
    } ctl_t;

    // Width of countdown timer i
    function automatic int down_width(int i);
        return (i == 2) ? 32 : 16;
    endfunction

    // Register base of countdown timer i
    function automatic int down_base(int i);
        return (i == 0) ? 'h00 : (i == 1) ? 'h20 : 'h80;
    endfunction
endpackage

// File: rtl/tmr_down.sv
// Countdown timer of parameter width W. It decrements on the selected tick
// while enabled. On a tick at zero it raises its interrupt and either reloads
// (periodic mode) or wraps to all ones. Assumes the write strobes are one-hot.
module tmr_down
    import tmr_pkg::*;
#(
    parameter int W  = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic          ctl_we,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    input  logic          tick_slow,
    input  logic          tick_mid,
    output logic [W-1:0]  cnt,
    output logic [W-1:0]  load,
    output ctl_t          ctl,
    output logic          irq
);
    logic tk;
    logic uf;

    assign tk = ctl.en && (ctl.sel ? tick_mid : tick_slow);
    assign uf = tk && (cnt == '0);

    // Reload value register
    always_ff @(posedge clk) begin
        if (!rst_n)     load <= '0;
        else if (ld_we) load <= wdata[W-1:0];
    end

    // Control bits
    always_ff @(posedge clk) begin
        if (!rst_n) ctl <= '0;
        else if (ctl_we) begin
            ctl.en  <= wdata[BIT_EN];
            ctl.per <= wdata[BIT_PER];
            ctl.sel <= wdata[BIT_SEL];
        end
    end

    // Live count: preset while disabled, otherwise count down on the tick
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (ld_we && !ctl.en)  cnt <= wdata[W-1:0];
        else if (uf)                cnt <= ctl.per ? load : '1;
        else if (tk)                cnt <= cnt - 1'b1;
    end

    // Interrupt flag: underflow sets it and wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)      irq <= 1'b0;
        else if (uf)     irq <= 1'b1;
        else if (clr_we) irq <= 1'b0;
    end
endmodule

// File: rtl/tmr_free.sv
// Free-running up-counter of width W. It adds one per tick while enabled and
// never interrupts. Assumes the enable is written as a single bit.
module tmr_free #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en_we,
    input  logic         en_wd,
    output logic [W-1:0] cnt,
    output logic         en
);
    // Enable bit register
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= 1'b0;
        else if (en_we) en <= en_wd;
    end

    // Counter advance
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (en && tick) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_bank.sv
// Timer bank top. It decodes the register bus into per-timer write strobes,
// instances three countdown timers of mixed width and one 40-bit free
// counter, and muxes read data. Read data is combinational in bus_addr.
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter int FREE_W = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick_slow,
    input  logic          tick_mid,
    input  logic          tick_free,
    output logic [N_DOWN-1:0] irq_o
);
    localparam int HI_W = FREE_W - DW;

    logic [DW-1:0] ld_ext  [N_DOWN];
    logic [DW-1:0] cnt_ext [N_DOWN];
    logic [DW-1:0] ctl_ext [N_DOWN];
    logic [FREE_W-1:0] free_cnt;
    logic              free_en;

    for (genvar i = 0; i < N_DOWN; i++) begin : g_down
        localparam int W  = down_width(i);
        localparam int BA = down_base(i);
        logic [W-1:0] cnt_w, ld_w;
        ctl_t         ctl_w;

        tmr_down #(.W(W), .DW(DW)) u_down (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_we     (bus_we && bus_addr == AW'(BA + OFS_LOAD)),
            .ctl_we    (bus_we && bus_addr == AW'(BA + OFS_CTL)),
            .clr_we    (bus_we && bus_addr == AW'(BA + OFS_CLR)),
            .wdata     (bus_wdata),
            .tick_slow (tick_slow),
            .tick_mid  (tick_mid),
            .cnt       (cnt_w),
            .load      (ld_w),
            .ctl       (ctl_w),
            .irq       (irq_o[i])
        );

        assign ld_ext[i]  = DW'(ld_w);
        assign cnt_ext[i] = DW'(cnt_w);
        always_comb begin
            ctl_ext[i]          = '0;
            ctl_ext[i][BIT_EN]  = ctl_w.en;
            ctl_ext[i][BIT_PER] = ctl_w.per;
            ctl_ext[i][BIT_SEL] = ctl_w.sel;
        end
    end

    tmr_free #(.W(FREE_W)) u_free (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_free),
        .en_we (bus_we && bus_addr == AW'(FREE_HI)),
        .en_wd (bus_wdata[FREE_EN_BIT]),
        .cnt   (free_cnt),
        .en    (free_en)
    );

    // Read data mux over the whole register map
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_DOWN; i++) begin
            if (bus_addr == AW'(down_base(i) + OFS_LOAD)) bus_rdata = ld_ext[i];
            if (bus_addr == AW'(down_base(i) + OFS_CNT))  bus_rdata = cnt_ext[i];
            if (bus_addr == AW'(down_base(i) + OFS_CTL))  bus_rdata = ctl_ext[i];
        end
        if (bus_addr == AW'(FREE_LO)) bus_rdata = free_cnt[DW-1:0];
        if (bus_addr == AW'(FREE_HI)) begin
            bus_rdata[HI_W-1:0]     = free_cnt[FREE_W-1:DW];
            bus_rdata[FREE_EN_BIT]  = free_en;
        end
    end
endmodule

// File: rtl/tmr_bank_chk.sv
// Checker for tmr_bank: interrupt hold and clear, free-counter stepping and
// unmapped reads. Attached to every tmr_bank instance by the bind below.
module tmr_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic        bus_we,
    input logic [31:0] bus_rdata,
    input logic        tick_slow,
    input logic        tick_mid,
    input logic        tick_free,
    input logic [2:0]  irq_o,
    input logic [39:0] free_cnt,
    input logic        free_en
);
    AST_IRQ0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] && !(bus_we && bus_addr == 8'h0C) |=> irq_o[0]); // R7
    AST_IRQ1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[1] && !(bus_we && bus_addr == 8'h2C) |=> irq_o[1]); // R7
    AST_IRQ2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[2] && !(bus_we && bus_addr == 8'h8C) |=> irq_o[2]); // R7
    AST_IRQ0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == 8'h0C && !tick_slow && !tick_mid |=> !irq_o[0]); // R7
    AST_NO_TICK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == 3'b000 && !tick_slow && !tick_mid |=> irq_o == 3'b000); // R5
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_free && free_en |=> free_cnt == $past(free_cnt) + 40'd1); // R10
    AST_FREE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_free |=> $stable(free_cnt)); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 8'h40 |-> bus_rdata == 32'h0); // R2
endmodule

bind tmr_bank tmr_bank_chk u_chk (.*);

// File: tb/tmr_bank_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural model updated at each rising edge and compared with
// irq_o and bus_rdata at every falling edge. Inputs change 1 ns after the
// falling edge.
module tmr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        tick_slow = 1'b0, tick_mid = 1'b0, tick_free = 1'b0;
    logic [2:0]  irq_o;

    int n_vec = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    tmr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .tick_slow(tick_slow),
        .tick_mid(tick_mid), .tick_free(tick_free), .irq_o(irq_o)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_ld [3], m_ct [3], m_mask [3];
    logic        m_en [3], m_per [3], m_sel [3], m_irq [3];
    logic [39:0] m_free;
    logic        m_fen;
    int          m_base [3] = '{'h00, 'h20, 'h80};

    initial begin
        m_mask[0] = 32'hFFFF; m_mask[1] = 32'hFFFF; m_mask[2] = 32'hFFFF_FFFF;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_ld[i] = 0; m_ct[i] = 0; m_en[i] = 0; m_per[i] = 0;
                m_sel[i] = 0; m_irq[i] = 0;
            end
            m_free = 0; m_fen = 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                bit tk, uf, wl, wc, wk;
                tk = m_en[i] && (m_sel[i] ? tick_mid : tick_slow);
                uf = tk && m_ct[i] == 0;
                wl = bus_we && bus_addr == 8'(m_base[i]);
                wc = bus_we && bus_addr == 8'(m_base[i] + 8);
                wk = bus_we && bus_addr == 8'(m_base[i] + 12);
                if (uf) m_ct[i] = m_per[i] ? m_ld[i] : m_mask[i];
                else if (tk) m_ct[i] = m_ct[i] - 1;
                if (wl) begin
                    m_ld[i] = bus_wdata & m_mask[i];
                    if (!m_en[i]) m_ct[i] = bus_wdata & m_mask[i];
                end
                if (wc) begin
                    m_en[i] = bus_wdata[7]; m_per[i] = bus_wdata[6]; m_sel[i] = bus_wdata[3];
                end
                if (uf) m_irq[i] = 1;
                else if (wk) m_irq[i] = 0;
            end
            if (m_fen && tick_free) m_free = m_free + 1;
            if (bus_we && bus_addr == 8'h64) m_fen = bus_wdata[8];
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [31:0] r = 0;
        for (int i = 0; i < 3; i++) begin
            if (a == 8'(m_base[i]))     r = m_ld[i];
            if (a == 8'(m_base[i] + 4)) r = m_ct[i];
            if (a == 8'(m_base[i] + 8)) r = {24'b0, m_en[i], m_per[i], 2'b0, m_sel[i], 3'b0};
        end
        if (a == 8'h60) r = m_free[31:0];
        if (a == 8'h64) r = {23'b0, m_fen, m_free[39:32]};
        return r;
    endfunction

    // Compare outputs with the model at every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [2:0]  ei;
            logic [31:0] er;
            ei = {m_irq[2], m_irq[1], m_irq[0]};
            er = m_read(bus_addr);
            n_vec++;
            if (irq_o !== ei || bus_rdata !== er) begin
                n_bad++;
                $display("FAIL %s addr=%h rdata=%h exp=%h irq=%b exp=%b",
                         cur_req, bus_addr, bus_rdata, er, irq_o, ei);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input logic [7:0] a, input logic we, input logic [31:0] d,
                        input logic ts, input logic tm, input logic tf);
        @(negedge clk); #1;
        bus_addr = a; bus_we = we; bus_wdata = d;
        tick_slow = ts; tick_mid = tm; tick_free = tf;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(a, 1'b1, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd(input logic [7:0] a);
        step(a, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    endtask

    // Watchdog: an expired run counts as one failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state read across the map
        cur_req = "R1";
        foreach (m_base[i]) for (int k = 0; k < 16; k += 4) rd(8'(m_base[i] + k));
        rd(8'h60); rd(8'h64);
        // R2 R3: control readback, unused bits dropped, unmapped address
        cur_req = "R3";
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08); wr(8'h08, 0); rd(8'h08);
        wr(8'h28, 32'h48); rd(8'h28); wr(8'h28, 0);
        cur_req = "R2";
        wr(8'h40, 32'h1234); rd(8'h40); rd(8'h0C);
        // R4 R11: disabled load copies and truncates
        cur_req = "R11";
        wr(8'h00, 32'h0012_3456); rd(8'h04); rd(8'h00);
        cur_req = "R4";
        wr(8'h80, 32'hDEAD_BEEF); rd(8'h84);
        // R5 R7: periodic timer 0, reload 3, underflow every 4 ticks
        cur_req = "R5";
        wr(8'h00, 3); wr(8'h08, 32'hC0);
        for (int t = 0; t < 12; t++) step(8'h04, 0, 0, 1, 0, 0);
        rd(8'h04);
        // R4: reload write while enabled leaves the count running
        cur_req = "R4";
        wr(8'h00, 9); rd(8'h04); step(8'h04, 0, 0, 1, 0, 0); rd(8'h00);
        // R7: clear, then clear in the same cycle as an underflow
        cur_req = "R7";
        wr(8'h0C, 32'h5A); rd(8'h04);
        wr(8'h00, 0); wr(8'h08, 0); wr(8'h00, 0); wr(8'h08, 32'hC0);
        step(8'h0C, 1, 0, 1, 0, 0); rd(8'h04);
        wr(8'h0C, 0); rd(8'h04);
        // R9: timer 1 on the fast tick ignores the slow tick
        cur_req = "R9";
        wr(8'h20, 5); wr(8'h28, 32'hC8);
        for (int t = 0; t < 4; t++) step(8'h24, 0, 0, 1, 0, 0);
        for (int t = 0; t < 8; t++) step(8'h24, 0, 0, 0, 1, 0);
        // R6: timer 2 in wrap mode goes to all ones
        cur_req = "R6";
        wr(8'h80, 1); wr(8'h88, 32'h80);
        for (int t = 0; t < 3; t++) step(8'h84, 0, 0, 1, 0, 0);
        wr(8'h8C, 0);
        wr(8'h20, 0); wr(8'h28, 32'h88); step(8'h24, 0, 0, 0, 1, 0); rd(8'h24);
        // R8: disabled count holds under ticks
        cur_req = "R8";
        wr(8'h88, 0);
        for (int t = 0; t < 4; t++) step(8'h84, 0, 0, 1, 1, 0);
        // R10: free counter enable, ticks, ignored low write
        cur_req = "R10";
        for (int t = 0; t < 3; t++) step(8'h60, 0, 0, 0, 0, 1);
        wr(8'h64, 32'h100);
        for (int t = 0; t < 20; t++) step(8'h60, 0, 0, 0, 0, 1);
        wr(8'h60, 32'hFFFF_FFFF); rd(8'h60); rd(8'h64);
        wr(8'h64, 0); step(8'h60, 0, 0, 0, 0, 1);
        // R5 R6 R7 R9 R10: random mix of writes and ticks
        cur_req = "random R5 R6 R7 R9 R10";
        for (int t = 0; t < 4000; t++) begin
            logic [7:0] a;
            int sel = $urandom_range(0, 13);
            a = (sel < 12) ? 8'(m_base[sel / 4] + 4 * (sel % 4)) : (sel == 12 ? 8'h60 : 8'h64);
            if ($urandom_range(0, 3) == 0)
                step(a, 1, (a[3:0] == 4'h8) ? $urandom : $urandom_range(0, 12),
                     $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
            else
                step(a, 0, 0, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
        end
        rd(8'h04);
        @(negedge clk); #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule